// File: doc/BRIEF.md
# PCI Interrupt Map and Gate

This block sits between 32 level-sensitive PCI interrupt lines and a downstream interrupt controller. The lines fall into eight groups of four consecutive lines. Each group has one 32-bit mapping register, and the top bit of that register is an enable. While a group is enabled, each of its outputs follows the level of the matching input. While a group is disabled, its outputs are held low. Software may change only the enable bit. The lower 31 bits of each register hold a fixed preset pattern that identifies the group.

Software reaches the registers through a simple 32-bit read/write port. The registers occupy a 64-byte window that starts at offset 0xC00. Each register takes the odd word of an 8-byte pair, and the even words read as zero. Reads return data one cycle after the strobe.

The block also holds a purely combinational helper. From a device/function number and an interrupt pin, it computes which of the 32 lines a device drives. It uses one rule for devices on the primary bus and another for devices behind a secondary bridge.

Top module: `pci_irq_map`

## Requirements
- R1: After reset, every enable bit is 0 and every output is low. Register n reads back as (0x1F << 6) | (n << 2) with bit 31 clear.
- R2: While bit 31 of mapping register n is 1, output k follows input k for every k with k >> 2 == n.
- R3: While bit 31 of mapping register n is 0, outputs 4n to 4n+3 are 0 whatever their inputs.
- R4: A write to a mapping register sets bit 31 to wdata[31]. Bits 30:0 keep their preset value whatever the write data.
- R5: Mapping register n is at byte offset 0xC00 + 8n + 4, with n taken from address bits 5:3 and bit 2 set. A read of the even word 0xC00 + 8n returns 0, and a write to it changes no enable bit.
- R6: Read data appears on the edge after the cycle with the read strobe high. It keeps its value while no read is strobed. Reset clears it to 0.
- R7: A read at an offset outside 0xC00..0xC3F returns 0, and a write there changes no enable bit.
- R8: When bridged_i is 0, line_idx_o = pin_i + 16 * devfn_i[0].
- R9: When bridged_i is 1, line_idx_o = 4 * devfn_i[4:3] + pin_i.
- R10: A change of an enable bit reaches the outputs right after the write edge, with no change of the inputs.
- R11: An asynchronous reset in mid-run clears all enable bits and leaves the preset bits 30:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 16 | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| irq_in_i | input | 32 | Level interrupt inputs |
| irq_out_o | output | 32 | Gated interrupt outputs |
| devfn_i | input | 8 | Device/function number for the index calculation |
| pin_i | input | 2 | Interrupt pin, 0 to 3 |
| bridged_i | input | 1 | 1 when the device sits behind a secondary bridge |
| line_idx_o | output | 5 | Interrupt line index driven by that device |

## Verification
The gated outputs and the line index depend combinationally on the current inputs and enable state, so they are due in the same cycle. An enable write shows on the outputs right after the edge that takes the write. Read data is due on the edge after the strobe. The bench applies stimulus between edges and updates its reference model at each rising edge. It compares every output 2 ns after that edge, so each result is checked in the cycle it is due, and an early or late read shows as a mismatch.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int unsigned NUM_LINES     = 32;
  localparam int unsigned LINES_PER_GRP = 4;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned ADDR_W        = 16;
  localparam int unsigned DEVFN_W       = 8;
  localparam int unsigned PIN_W         = 2;
  localparam logic [15:0] WIN_BASE      = 16'h0C00;
  localparam logic [31:0] PRESET_HI     = 32'h0000_07C0;

  // fixed low bits of mapping register n
  function automatic logic [DATA_W-2:0] preset_bits(int unsigned n);
    logic [DATA_W-1:0] v;
    v = PRESET_HI | (DATA_W'(n) << 2);
    return v[DATA_W-2:0];
  endfunction
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_map_pkg::*;
#(
  parameter int unsigned NUM_GRP = NUM_LINES / LINES_PER_GRP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_GRP-1:0] en_o
);
  localparam int unsigned GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int unsigned WIN_LSB = GRP_W + 3;

  logic             win_hit, odd_word, reg_sel;
  logic [GRP_W-1:0] grp;
  logic [DATA_W-1:0] rd_val;
  logic [NUM_GRP-1:0] en_q;

  assign win_hit  = addr_i[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB];
  assign odd_word = addr_i[2];
  assign grp      = addr_i[WIN_LSB-1:3];
  assign reg_sel  = win_hit && odd_word;

  // only the enable bit is stored; low bits are constants
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   en_q[g] <= 1'b0;
      else if (wr_i && reg_sel && grp == GRP_W'(g))  en_q[g] <= wdata_i[DATA_W-1];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_sel && grp == GRP_W'(g)) rd_val = {en_q[g], preset_bits(g)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assign en_o = en_q;

  a_r4_low_bits_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && reg_sel) |=> rdata_o[DATA_W-2:0] == preset_bits(int'($past(grp))));
  a_r5_even_word_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && win_hit && !odd_word) |=> rdata_o == '0);
  a_r7_outside_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !win_hit) |=> rdata_o == '0);
  a_r6_hold_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r7_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !reg_sel) |=> $stable(en_q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_map_pkg::*;
#(
  parameter int unsigned LINES = NUM_LINES,
  parameter int unsigned PER   = LINES_PER_GRP,
  parameter int unsigned GRPS  = LINES / PER
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] irq_i,
  input  logic [GRPS-1:0]  en_i,
  output logic [LINES-1:0] irq_o
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign irq_o[k] = irq_i[k] & en_i[k / PER];
  end

  a_r3_never_above_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~irq_i) == '0);
  a_r2_open_group_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '1) |-> irq_o == irq_i);
endmodule

// File: rtl/irq_line_index.sv
module irq_line_index
  import irq_map_pkg::*;
#(
  parameter int unsigned LINE_W = $clog2(NUM_LINES)
) (
  input  logic [DEVFN_W-1:0] devfn_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic               bridged_i,
  output logic [LINE_W-1:0]  line_o
);
  localparam int unsigned HALF = NUM_LINES / 2;

  logic [LINE_W-1:0] prim_idx, sec_idx;

  assign prim_idx = LINE_W'(pin_i) + (devfn_i[0] ? LINE_W'(HALF) : '0);
  assign sec_idx  = (LINE_W'(devfn_i[4:3]) << 2) + LINE_W'(pin_i);
  assign line_o   = bridged_i ? sec_idx : prim_idx;

  always_comb begin
    a_r9_sec_below_half: assert (sec_idx < LINE_W'(HALF));
  end
endmodule

// File: rtl/pci_irq_map.sv
module pci_irq_map
  import irq_map_pkg::*;
#(
  parameter int unsigned N_LINES = NUM_LINES,
  parameter int unsigned PER_GRP = LINES_PER_GRP,
  localparam int unsigned N_GRP  = N_LINES / PER_GRP,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [N_LINES-1:0]  irq_in_i,
  output logic [N_LINES-1:0]  irq_out_o,
  input  logic [DEVFN_W-1:0]  devfn_i,
  input  logic [PIN_W-1:0]    pin_i,
  input  logic                bridged_i,
  output logic [IDX_W-1:0]    line_idx_o
);
  logic [N_GRP-1:0] grp_en;

  irq_map_regs #(.NUM_GRP(N_GRP)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .en_o(grp_en)
  );

  irq_gate #(.LINES(N_LINES), .PER(PER_GRP), .GRPS(N_GRP)) u_gate (
    .clk_i, .rst_ni, .irq_i(irq_in_i), .en_i(grp_en), .irq_o(irq_out_o)
  );

  irq_line_index #(.LINE_W(IDX_W)) u_index (
    .devfn_i, .pin_i, .bridged_i, .line_o(line_idx_o)
  );

  a_r10_enable_next_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 16'h0C04 && reg_wdata_i[31] && $stable(irq_in_i))
      |=> (irq_out_o[PER_GRP-1:0] == $past(irq_in_i[PER_GRP-1:0]) || !$stable(irq_in_i)));
endmodule

// File: tb/pci_irq_map_tb_top.sv
module pci_irq_map_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] irq_in_i = '0;
  logic [31:0] irq_out_o;
  logic [7:0]  devfn_i = '0;
  logic [1:0]  pin_i = '0;
  logic        bridged_i = 1'b0;
  logic [4:0]  line_idx_o;

  int tests = 0, fails = 0;
  bit [7:0]  ref_en = '0;
  bit [31:0] ref_rdata = '0;

  always #4 clk_i = ~clk_i;

  pci_irq_map dut_i (.*);

  function automatic bit [31:0] model_read(bit [15:0] a, bit [7:0] en);
    int n;
    if (a >= 16'h0C00 && a < 16'h0C40 && a[2]) begin
      n = int'(a[5:3]);
      return {en[n], 31'((32'h1F << 6) | (n << 2))};
    end
    return 32'h0;
  endfunction

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string rd_req);
    bit [31:0] exp_out;
    int idx;
    for (int k = 0; k < 32; k++) exp_out[k] = irq_in_i[k] & ref_en[k/4];
    check((ref_en == 8'h00) ? "R3 gated outputs" : "R2/R3 gated outputs", irq_out_o, exp_out);
    if (bridged_i) idx = ((int'(devfn_i) & 'h18) >> 1) + int'(pin_i);
    else           idx = int'(pin_i) + (devfn_i[0] ? 16 : 0);
    check(bridged_i ? "R9 secondary index" : "R8 primary index", 32'(line_idx_o), 32'(idx));
    check(rd_req, reg_rdata_o, ref_rdata);
  endtask

  // one clock: model update at the edge, compare 2 ns later
  task automatic cycle(string rd_req);
    @(posedge clk_i);
    if (rst_ni) begin
      if (reg_rd_i) ref_rdata = model_read(reg_addr_i, ref_en);
      if (reg_wr_i && reg_addr_i >= 16'h0C00 && reg_addr_i < 16'h0C40 && reg_addr_i[2])
        ref_en[reg_addr_i[5:3]] = reg_wdata_i[31];
    end
    #2;
    compare_all(rd_req);
    irq_in_i  = $urandom;
    devfn_i   = 8'($urandom);
    pin_i     = 2'($urandom);
    bridged_i = 1'($urandom);
    reg_wr_i  = 1'b0;
    reg_rd_i  = 1'b0;
  endtask

  task automatic do_read(bit [15:0] a, string req);
    reg_rd_i = 1'b1; reg_addr_i = a;
    cycle(req);
    cycle("R6 hold after read");
  endtask

  task automatic do_write(bit [15:0] a, bit [31:0] d, string req);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cycle(req);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3;
    compare_all("R1 reset read data");
    #20;
    rst_ni = 1'b1;
    // R1: preset values with enable clear
    for (int n = 0; n < 8; n++) do_read(16'h0C04 + 16'(8*n), "R1 preset readback");
    // R5: even words read zero
    for (int n = 0; n < 8; n++) do_read(16'h0C00 + 16'(8*n), "R5 even word");
    // R7: outside window
    do_read(16'h0C40, "R7 outside read");
    do_read(16'h2004, "R7 outside read");
    do_read(16'h0BFC, "R7 outside read");
    // R4: enable with noisy low bits
    for (int n = 0; n < 8; n += 2) do_write(16'h0C04 + 16'(8*n), 32'h8000_0000 | $urandom, "R4 write");
    for (int n = 0; n < 8; n++) do_read(16'h0C04 + 16'(8*n), "R4 low bits fixed");
    // R5/R7: stray writes must not touch enables
    do_write(16'h0C08, 32'h8000_0000, "R5 even write ignored");
    do_write(16'h0C44, 32'h8000_0000, "R7 outside write ignored");
    do_write(16'h1C0C, 32'h8000_0000, "R7 outside write ignored");
    do_read(16'h0C0C, "R5 even write left enable");
    for (int i = 0; i < 20; i++) cycle("R2 random inputs");
    // R10: hold inputs high, toggle enable
    do_write(16'h0C0C, 32'h8000_0000, "R10 write");
    irq_in_i = '1;
    @(posedge clk_i); #2; compare_all("R10 held");
    reg_wr_i = 1'b1; reg_addr_i = 16'h0C1C; reg_wdata_i = 32'h8000_0000;
    @(posedge clk_i);
    ref_en[3] = 1'b1;
    #2; compare_all("R10 enable effect");
    reg_wr_i = 1'b0;
    check("R10 group 3 lines high", 32'(irq_out_o[15:12]), 32'hF);
    reg_wr_i = 1'b1; reg_addr_i = 16'h0C04; reg_wdata_i = 32'h7FFF_FFFF;
    @(posedge clk_i);
    ref_en[0] = 1'b0;
    #2; compare_all("R10 disable effect");
    reg_wr_i = 1'b0;
    check("R3 group 0 lines low", 32'(irq_out_o[3:0]), 32'h0);
    // read and write same register in one cycle: read sees old
    reg_wr_i = 1'b1; reg_rd_i = 1'b1; reg_addr_i = 16'h0C14; reg_wdata_i = 32'h0;
    cycle("R6 read old value");
    for (int i = 0; i < 100; i++) begin
      if (($urandom % 4) == 0) begin
        reg_wr_i = 1'b1; reg_addr_i = 16'h0C00 + 16'($urandom % 64); reg_wdata_i = $urandom;
      end
      if (($urandom % 3) == 0) begin
        reg_rd_i = 1'b1; reg_addr_i = 16'h0C00 + 16'($urandom % 64);
      end
      cycle("R6 random access");
    end
    // R11: mid-run reset
    do_write(16'h0C3C, 32'h8000_0000, "R11 pre-reset write");
    rst_ni = 1'b0;
    ref_en = '0; ref_rdata = '0;
    #1; compare_all("R11 async reset");
    cycle("R11 in reset");
    rst_ni = 1'b1;
    for (int n = 0; n < 8; n++) do_read(16'h0C04 + 16'(8*n), "R11 preset kept, enable cleared");
    for (int i = 0; i < 10; i++) cycle("R3 all gated after reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule